// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block passes data between an A side and a B side through two independent storage registers, one per direction. Each register has its own rising-edge clock and an active-low clock enable that covers the full width. The data path is split into equal groups; every group has its own active-low output enable for each direction. This lets one group drive a side while another group on the same side is isolated.

The block has no tri-state nets. Each side is modelled as a receive vector, a transmit vector and a per-bit drive-enable vector. A side that is isolated reports its enable as 0 and its transmit bits as 0. The A side has a bus keeper for each bit. When neither the far end nor the block drives a bit, the keeper holds the last level seen on it, and that held level is what the A-to-B register samples.

There is no reset. Register contents are undefined until the first enabled clock edge of each direction. The output stages, however, are defined from time zero.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On a rising edge of `clk_ab` with `ce_ab_n` = 0, the A-to-B register captures the effective A value of each bit.
- R2: On a rising edge of `clk_ab` with `ce_ab_n` = 1, the A-to-B register keeps its previous contents, whatever the A value is.
- R3: While `clk_ab` or `clk_ba` has no rising edge, the matching register keeps its value, even when its data input and clock enable change.
- R4: Group g covers bits g*GROUP_W to g*GROUP_W+GROUP_W-1. With `oe_ab_n[g]` = 1, those `b_oe` bits are 0 and those `b_out` bits are 0. With `oe_ab_n[g]` = 0, those `b_oe` bits are 1 and those `b_out` bits show the A-to-B register.
- R5: The output enables of different groups act independently. Every one of the 2^GROUPS enable combinations drives exactly the selected groups.
- R6: On a rising edge of `clk_ba` with `ce_ba_n` = 0, the B-to-A register captures `b_in`. With `ce_ba_n` = 1, it holds its contents.
- R7: `oe_ba_n[g]` controls the `a_oe`/`a_out` bits of group g in the same way as R4. Within one group, the two directions must never both be enabled.
- R8: The effective A value of a bit is `a_in` when `a_drv` is 1. Otherwise it is `a_out` when `a_oe` is 1. Otherwise it is the last effective value the bit had while it was driven.
- R9: Data loaded at an enabled edge is visible on an enabled output straight after that edge, with no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B register clock, rising edge |
| clk_ba | input | 1 | B-to-A register clock, rising edge |
| ce_ab_n | input | 1 | A-to-B clock enable, active low, all bits |
| ce_ba_n | input | 1 | B-to-A clock enable, active low, all bits |
| oe_ab_n | input | GROUPS | Per-group B-side output enable, active low |
| oe_ba_n | input | GROUPS | Per-group A-side output enable, active low |
| a_in | input | GROUP_W*GROUPS | Level applied to the A side by external drivers |
| a_drv | input | GROUP_W*GROUPS | 1 where an external driver is active on the A side |
| a_out | output | GROUP_W*GROUPS | A-side transmit data (0 where isolated) |
| a_oe | output | GROUP_W*GROUPS | A-side drive enable per bit |
| b_in | input | GROUP_W*GROUPS | Level on the B side |
| b_out | output | GROUP_W*GROUPS | B-side transmit data (0 where isolated) |
| b_oe | output | GROUP_W*GROUPS | B-side drive enable per bit |

## Verification
The bench builds the block with GROUP_W = 3 and GROUPS = 2, so each side is 6 bits wide. At that size it can push all 64 data words through each direction and try all four output-enable combinations per direction. It can also sweep all 64 external-drive masks over the A keeper, so every mix of driven and floating bits is covered. Expected words are formed by masking and merging in the bench. The case where the block's own A transmit value is what the keeper holds is covered separately.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_GROUP_W = 9;
  localparam int unsigned DEF_GROUPS  = 2;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] ext_drv,
  input  logic [W-1:0] own_val,
  input  logic [W-1:0] own_drv,
  output logic [W-1:0] line
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic driven;
    logic drive_val;
    logic held;

    assign driven    = ext_drv[i] | own_drv[i];
    assign drive_val = ext_drv[i] ? ext_val[i] : own_val[i];

    // Transparent while someone drives the bit, holds once released.
    always_latch begin
      if (driven) held = drive_val;
    end

    assign line[i] = driven ? drive_val : held;
  end
endmodule

// File: rtl/xcvr_dir_reg.sv
module xcvr_dir_reg #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!ce_n) q <= d;
  end

  // R1 / R6: an enabled edge stores the data present at that edge
  a_r1_load: assert property (@(posedge clk) !ce_n |=> q == $past(d));
  // R2 / R6: a disabled edge leaves the contents untouched
  a_r2_hold: assert property (@(posedge clk) ce_n |=> $stable(q));
endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage #(
  parameter int unsigned GROUP_W = 9,
  parameter int unsigned GROUPS  = 2,
  localparam int unsigned W      = GROUP_W * GROUPS
) (
  input  logic [W-1:0]      q,
  input  logic [GROUPS-1:0] oe_n,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      den
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GROUP_W;
    assign den[LO +: GROUP_W]  = {GROUP_W{~oe_n[g]}};
    assign dout[LO +: GROUP_W] = oe_n[g] ? '0 : q[LO +: GROUP_W];
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int unsigned GROUP_W = xcvr_pkg::DEF_GROUP_W,
  parameter int unsigned GROUPS  = xcvr_pkg::DEF_GROUPS,
  localparam int unsigned W      = GROUP_W * GROUPS
) (
  input  logic              clk_ab,
  input  logic              clk_ba,
  input  logic              ce_ab_n,
  input  logic              ce_ba_n,
  input  logic [GROUPS-1:0] oe_ab_n,
  input  logic [GROUPS-1:0] oe_ba_n,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      a_drv,
  output logic [W-1:0]      a_out,
  output logic [W-1:0]      a_oe,
  input  logic [W-1:0]      b_in,
  output logic [W-1:0]      b_out,
  output logic [W-1:0]      b_oe
);
  logic [W-1:0] a_line;
  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;

  xcvr_keeper #(.W(W)) u_keeper (
    .ext_val(a_in), .ext_drv(a_drv),
    .own_val(a_out), .own_drv(a_oe),
    .line(a_line)
  );

  xcvr_dir_reg #(.W(W)) u_reg_ab (
    .clk(clk_ab), .ce_n(ce_ab_n), .d(a_line), .q(q_ab)
  );

  xcvr_dir_reg #(.W(W)) u_reg_ba (
    .clk(clk_ba), .ce_n(ce_ba_n), .d(b_in), .q(q_ba)
  );

  xcvr_out_stage #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_out_b (
    .q(q_ab), .oe_n(oe_ab_n), .dout(b_out), .den(b_oe)
  );

  xcvr_out_stage #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_out_a (
    .q(q_ba), .oe_n(oe_ba_n), .dout(a_out), .den(a_oe)
  );

  always @(posedge clk_ab) begin
    // R5: the number of driving B bits tracks the number of enabled groups
    a_r5_group_count: assert ($countones(b_oe) ==
                              GROUP_W * (GROUPS - $countones(oe_ab_n)));
    // R7: A side follows the same per-group rule
    a_r7_a_group_count: assert ($countones(a_oe) ==
                                GROUP_W * (GROUPS - $countones(oe_ba_n)));
    // R7: no group may drive both sides at once
    a_r7_no_contention: assert ((~oe_ab_n & ~oe_ba_n) == '0);
  end
endmodule

// File: tb/dual_reg_xcvr_tb.sv
module dual_reg_xcvr_tb;
  localparam int GW = 3;
  localparam int NG = 2;
  localparam int W  = GW * NG;
  localparam logic [W-1:0] ALL = '1;

  logic clk_ab = 0, clk_ba = 0, ce_ab_n = 1, ce_ba_n = 1;
  logic [NG-1:0] oe_ab_n = '1, oe_ba_n = '1;
  logic [W-1:0] a_in = '0, a_drv = '1, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;

  dual_reg_xcvr #(.GROUP_W(GW), .GROUPS(NG)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .ce_ab_n(ce_ab_n), .ce_ba_n(ce_ba_n),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .a_in(a_in), .a_drv(a_drv),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // 4 ns period pulses (250 MHz), inputs change only while the clock is low
  task automatic pulse_ab();
    #1 clk_ab = 1; #2 clk_ab = 0; #1;
  endtask
  task automatic pulse_ba();
    #1 clk_ba = 1; #2 clk_ba = 0; #1;
  endtask

  function automatic logic [W-1:0] grp_mask(input logic [NG-1:0] oe_n);
    logic [W-1:0] m = '0;
    for (int g = 0; g < NG; g++)
      if (!oe_n[g]) m |= ((1 << GW) - 1) << (g * GW);
    return m;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    #2;
    // R4 / R7: isolated state straight after power-up
    chk("R4 b_oe isolated", b_oe, '0);
    chk("R4 b_out isolated", b_out, '0);
    chk("R7 a_oe isolated", a_oe, '0);
    chk("R7 a_out isolated", a_out, '0);

    // R1 / R9: every A word, visible right after the loading edge
    oe_ab_n = '0;
    for (int v = 0; v < (1 << W); v++) begin
      a_in = v[W-1:0]; ce_ab_n = 0;
      pulse_ab();
      chk("R1 R9 a-to-b load", b_out, v[W-1:0]);
    end
    chk("R4 b_oe all enabled", b_oe, ALL);

    // R4 / R5: each group enable combination
    a_in = 6'b101_110; pulse_ab();
    for (int e = 0; e < (1 << NG); e++) begin
      oe_ab_n = e[NG-1:0]; #1;
      chk("R4 R5 b_oe groups", b_oe, grp_mask(e[NG-1:0]));
      chk("R4 R5 b_out groups", b_out, 6'b101_110 & grp_mask(e[NG-1:0]));
    end
    oe_ab_n = '0;

    // R2: disabled edge ignores new data
    ce_ab_n = 1; a_in = 6'b010_001; pulse_ab();
    chk("R2 hold on ce high", b_out, 6'b101_110);
    // R3: no edge, enable low and data changing
    ce_ab_n = 0; a_in = 6'b111_000; #20;
    chk("R3 hold without edge", b_out, 6'b101_110);
    pulse_ab();
    chk("R9 same-edge enable", b_out, 6'b111_000);
    oe_ab_n = '1; ce_ab_n = 1; #1;

    // R6: every B word through the B-to-A path
    oe_ba_n = '0;
    for (int v = 0; v < (1 << W); v++) begin
      b_in = v[W-1:0]; ce_ba_n = 0;
      pulse_ba();
      chk("R6 b-to-a load", a_out, v[W-1:0]);
    end
    ce_ba_n = 1; b_in = 6'b000_111; pulse_ba();
    chk("R6 hold on ce high", a_out, 6'b111_111);
    ce_ba_n = 0; b_in = 6'b100_100; #20;
    chk("R3 b-to-a hold without edge", a_out, 6'b111_111);
    pulse_ba();
    for (int e = 0; e < (1 << NG); e++) begin
      oe_ba_n = e[NG-1:0]; #1;
      chk("R7 a_oe groups", a_oe, grp_mask(e[NG-1:0]));
      chk("R7 a_out groups", a_out, 6'b100_100 & grp_mask(e[NG-1:0]));
    end
    oe_ba_n = '1; ce_ba_n = 1; #1;

    // R8: keeper holds released bits, for every drive mask
    for (int m = 0; m < (1 << W); m++) begin
      held = m[W-1:0] ^ 6'b011_010;
      oe_ab_n = '1;
      a_drv = ALL; a_in = held; #1;
      a_drv = m[W-1:0]; a_in = ~held; #1;
      ce_ab_n = 0; pulse_ab(); ce_ab_n = 1;
      oe_ab_n = '0; #1;
      chk("R8 keeper mask", b_out, (~held & m[W-1:0]) | (held & ~m[W-1:0]));
    end

    // R8: keeper follows the block's own A drive, then holds it
    oe_ab_n = '1; a_drv = '0;
    b_in = 6'b110_011; ce_ba_n = 0; pulse_ba(); ce_ba_n = 1;
    oe_ba_n = '0; #1;
    ce_ab_n = 0; pulse_ab(); ce_ab_n = 1;
    oe_ba_n = '1; #1;
    oe_ab_n = '0; #1;
    chk("R8 keeper own drive", b_out, 6'b110_011);
    oe_ab_n = '1; #1;
    ce_ab_n = 0; pulse_ab(); ce_ab_n = 1;
    oe_ab_n = '0; #1;
    chk("R8 keeper after release", b_out, 6'b110_011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule